// File: doc/BRIEF.md
# NAND Flash Controller Status and Interrupt Registers

This block holds the control word and the event-status word of a NAND flash controller and drives that controller's single interrupt line. The controller core reports events as one-cycle pulses. Each pulse latches a sticky flag in the status word. Software clears a flag by writing a one to its bit position. Each of the twelve low status flags is paired with a mask bit in the control word. A mask bit of one silences its source, and a mask bit of zero lets the source raise the interrupt.

The control word also holds the four mode bits the core acts on: spare-area enable, ECC enable, DMA enable and a run bit. Software sets run to start an operation. The bit drops by itself when the core signals completion, so software can poll it as a busy flag. Command words written to the command-buffer offset pass to the core only while run is set. When the controller clock is gated off and back on, the core pulses a resume input, and the status word then reads as flash-ready plus controller-ready.

Registers are reached over a simple 32-bit bus. Writes take effect at the clock edge. Read data is registered and is valid one cycle after the read strobe.

Top module: `nfc_stat_irq`

## Requirements
- R1: After reset the control word reads 0x00000FFF (all twelve mask bits set, run and the three enables clear), the status word reads 0, and irq_o, run_o and cmd_vld_o are low.
- R2: The control word is at offset 0x0. Bit 31 is spare enable, bit 30 is ECC enable, bit 29 is DMA enable, bit 28 is run, and bits 11:0 are the interrupt masks. Bits 27:12 are not stored and read as zero.
- R3: The status word is at offset 0x4 and has 13 bits. Bit 0 is the write-command request, bit 1 the read-data request, bit 2 the write-data request, bit 3 the single-bit error, bit 4 the double-bit error, bits 5 and 6 bad block for chip select 1 and 0, bits 7 and 8 command done for chip select 1 and 0, bits 9 and 10 page done for chip select 1 and 0, bit 11 flash ready and bit 12 controller ready. A pulse on evt_set_i[n] sets bit n, and the bit stays set.
- R4: Writing the status word clears exactly the bits written as one. Bits written as zero keep their value, so writing 0xFFF clears bits 11:0 and leaves bit 12 unchanged.
- R5: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R6: irq_o is the registered OR, over bits 11:0, of each status bit ANDed with the inverse of its mask bit. It rises one cycle after the flag becomes visible, and a masked flag never raises it.
- R7: Status bit 12 never drives irq_o.
- R8: A pulse on core_done_i clears run in the next cycle. If a control write in that same cycle sets run, the completion wins and run reads 0.
- R9: A control write with bit 28 at zero stops the controller (run_o goes low).
- R10: A write to offset 0x8 while run is set produces a one-cycle cmd_vld_o pulse with the written word on cmd_word_o in the next cycle. While run is clear, the write is dropped and cmd_vld_o stays low.
- R11: A pulse on clk_resume_i loads the status word with 0x1800, which sets bits 11 and 12 and clears all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid one cycle after bus_rd_i |
| evt_set_i | input | 13 | Event pulses from the core, one per status bit |
| core_done_i | input | 1 | Pulse from the core when an operation finishes |
| clk_resume_i | input | 1 | Pulse when the controller clock returns after gating |
| irq_o | output | 1 | Registered interrupt request |
| run_o | output | 1 | Run bit |
| dma_en_o | output | 1 | DMA enable |
| ecc_en_o | output | 1 | ECC enable |
| spare_en_o | output | 1 | Spare-area enable |
| cmd_vld_o | output | 1 | Command word valid toward the core |
| cmd_word_o | output | 32 | Command word toward the core |

## Verification
The in-line properties assume that event, completion and resume inputs are single-cycle pulses driven synchronously to clk. They also assume that the resume pulse never coincides with an event pulse or a status write, since the resume load would mask what those properties expect. The bench drives all inputs on the falling edge and keeps resume pulses isolated from other traffic. Simultaneous event and clear is exercised only on purpose, to check the set-wins rule.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int DATA_W   = 32;
  localparam int STAT_W   = 13;
  localparam int MASK_W   = 12;
  localparam int RUN_BIT  = 28;
  localparam int DMA_BIT  = 29;
  localparam int ECC_BIT  = 30;
  localparam int SPR_BIT  = 31;
  localparam logic [STAT_W-1:0] RESUME_VAL = 13'h1800;

  typedef struct packed {
    logic             spare;
    logic             ecc;
    logic             dma;
    logic             run;
    logic [MASK_W-1:0] mask;
  } ctrl_t;
endpackage

// File: rtl/nfc_ctrl_reg.sv
module nfc_ctrl_reg
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_mode,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              core_done,
  output ctrl_t             ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.spare <= 1'b0;
      ctrl_q.ecc   <= 1'b0;
      ctrl_q.dma   <= 1'b0;
      ctrl_q.run   <= 1'b0;
      ctrl_q.mask  <= '1;
    end else begin
      if (wr_en) begin
        ctrl_q.spare <= wr_mode[3];
        ctrl_q.ecc   <= wr_mode[2];
        ctrl_q.dma   <= wr_mode[1];
        ctrl_q.run   <= wr_mode[0];
        ctrl_q.mask  <= wr_mask;
      end
      if (core_done) ctrl_q.run <= 1'b0;
    end
  end

  // R8: completion always drops run
  assert_done_clears_run_R8: assert property (@(posedge clk) disable iff (rst)
    core_done |=> !ctrl_q.run);
endmodule

// File: rtl/nfc_stat_reg.sv
module nfc_stat_reg
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] evt,
  input  logic              resume,
  output logic [STAT_W-1:0] stat_q
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (resume)
        stat_q[i] <= RESUME_VAL[i];
      else if (evt[i])
        stat_q[i] <= 1'b1;
      else if (clr_en && clr_bits[i])
        stat_q[i] <= 1'b0;
    end

    // R3 and R5: an event leaves its flag set, even against a clear
    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && !resume) |=> stat_q[i]);
    // R4: a clear with no competing event empties the flag
    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_en && clr_bits[i] && !evt[i] && !resume) |=> !stat_q[i]);
  end

  // R11: resume loads the fixed pattern
  assert_resume_R11: assert property (@(posedge clk) disable iff (rst)
    resume |=> (stat_q == RESUME_VAL));
endmodule

// File: rtl/nfc_irq_gen.sv
module nfc_irq_gen
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic [MASK_W-1:0] mask,
  output logic              irq_q
);
  logic [MASK_W-1:0] live;
  assign live = stat[MASK_W-1:0] & ~mask;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |live;
  end

  // R6: a fully masked word cannot raise the line next cycle
  assert_full_mask_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !irq_q);
  // R7: controller-ready alone never raises the line
  assert_bit12_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (stat[MASK_W-1:0] == '0) |=> !irq_q);
endmodule

// File: rtl/nfc_stat_irq.sv
module nfc_stat_irq
  import nfc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4,
  parameter int CMD_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [12:0]       evt_set_i,
  input  logic              core_done_i,
  input  logic              clk_resume_i,
  output logic              irq_o,
  output logic              run_o,
  output logic              dma_en_o,
  output logic              ecc_en_o,
  output logic              spare_en_o,
  output logic              cmd_vld_o,
  output logic [31:0]       cmd_word_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);

  logic sel_ctrl, sel_stat, sel_cmd;
  assign sel_ctrl = bus_addr_i == A_CTRL;
  assign sel_stat = bus_addr_i == A_STAT;
  assign sel_cmd  = bus_addr_i == A_CMD;

  ctrl_t             ctrl_q;
  logic [STAT_W-1:0] stat_q;

  nfc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr_i && sel_ctrl),
    .wr_mode   (bus_wdata_i[SPR_BIT:RUN_BIT]),
    .wr_mask   (bus_wdata_i[MASK_W-1:0]),
    .core_done (core_done_i),
    .ctrl_q    (ctrl_q)
  );

  nfc_stat_reg u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (bus_wr_i && sel_stat),
    .clr_bits (bus_wdata_i[STAT_W-1:0]),
    .evt      (evt_set_i),
    .resume   (clk_resume_i),
    .stat_q   (stat_q)
  );

  nfc_irq_gen u_irq (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat_q),
    .mask  (ctrl_q.mask),
    .irq_q (irq_o)
  );

  assign run_o      = ctrl_q.run;
  assign dma_en_o   = ctrl_q.dma;
  assign ecc_en_o   = ctrl_q.ecc;
  assign spare_en_o = ctrl_q.spare;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[SPR_BIT]      = ctrl_q.spare;
      rd_mux[ECC_BIT]      = ctrl_q.ecc;
      rd_mux[DMA_BIT]      = ctrl_q.dma;
      rd_mux[RUN_BIT]      = ctrl_q.run;
      rd_mux[MASK_W-1:0]   = ctrl_q.mask;
    end else if (sel_stat) begin
      rd_mux[STAT_W-1:0]   = stat_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      cmd_vld_o   <= 1'b0;
      cmd_word_o  <= '0;
    end else begin
      if (bus_rd_i) bus_rdata_o <= rd_mux;
      cmd_vld_o <= bus_wr_i && sel_cmd && ctrl_q.run;
      if (bus_wr_i && sel_cmd && ctrl_q.run) cmd_word_o <= bus_wdata_i;
    end
  end

  // R10: a command word only reaches the core while running
  assert_cmd_needs_run_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |-> $past(run_o));
endmodule

// File: tb/tb_nfc_stat_irq.sv
module tb_nfc_stat_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_i = 0, bus_rd_i = 0;
  logic [3:0]  bus_addr_i = 0;
  logic [31:0] bus_wdata_i = 0;
  logic [31:0] bus_rdata_o;
  logic [12:0] evt_set_i = 0;
  logic        core_done_i = 0, clk_resume_i = 0;
  logic        irq_o, run_o, dma_en_o, ecc_en_o, spare_en_o, cmd_vld_o;
  logic [31:0] cmd_word_o;

  always #2.5 clk = ~clk;

  nfc_stat_irq dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_i = 1; bus_addr_i = a;
    @(negedge clk);
    bus_rd_i = 0;
    d = bus_rdata_o;
  endtask

  task automatic ev(input logic [12:0] e);
    @(negedge clk);
    evt_set_i = e;
    @(negedge clk);
    evt_set_i = 0;
  endtask

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 event, 2 read and compare
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 4'h0, 32'h0,        32'h00000FFF},  // R1
    '{2'd2, 4'h4, 32'h0,        32'h00000000},  // R1
    '{2'd0, 4'h0, 32'hF0000000, 32'h0},
    '{2'd2, 4'h0, 32'h0,        32'hF0000000},  // R2
    '{2'd1, 4'h0, 32'h00000005, 32'h0},
    '{2'd2, 4'h4, 32'h0,        32'h00000005},  // R3
    '{2'd0, 4'h4, 32'h00000001, 32'h0},
    '{2'd2, 4'h4, 32'h0,        32'h00000004},  // R4
    '{2'd1, 4'h0, 32'h00001800, 32'h0},
    '{2'd2, 4'h4, 32'h0,        32'h00001804},  // R3
    '{2'd0, 4'h4, 32'h00000FFF, 32'h0},
    '{2'd2, 4'h4, 32'h0,        32'h00001000},  // R4
    '{2'd0, 4'h0, 32'h0000F0F0, 32'h0},
    '{2'd2, 4'h0, 32'h0,        32'h000000F0}   // R2 and R9
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({irq_o, run_o, cmd_vld_o}, 0, "R1 outputs after reset");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: ev(VEC[i].data[12:0]);
        default: begin
          rd(VEC[i].addr, d);
          chk(d, VEC[i].exp, $sformatf("R2/R3/R4 vector %0d", i));
        end
      endcase
    end
    chk(run_o, 0, "R9 run cleared by write");

    // clear status, unmask all
    wr(4'h4, 32'h1FFF);
    wr(4'h0, 32'h0);
    // R6 timing: irq low right after the flag appears, high one cycle later
    @(negedge clk); evt_set_i = 13'h0008;
    @(negedge clk); evt_set_i = 0;
    chk(irq_o, 0, "R6 irq not before flag register");
    @(negedge clk);
    chk(irq_o, 1, "R6 irq one cycle after flag");
    // mask bit 3 -> irq drops
    wr(4'h0, 32'h00000008);
    @(negedge clk);
    chk(irq_o, 0, "R6 masked flag quiet");
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h1FFF);
    @(negedge clk);
    chk(irq_o, 0, "R4 irq gone after clear");

    // R7: controller-ready alone never interrupts
    ev(13'h1000);
    repeat (2) @(negedge clk);
    chk(irq_o, 0, "R7 bit 12 no irq");
    wr(4'h4, 32'h1FFF);

    // R5: event and clear in the same cycle
    @(negedge clk);
    evt_set_i = 13'h0100; bus_wr_i = 1; bus_addr_i = 4'h4; bus_wdata_i = 32'h0100;
    @(negedge clk);
    evt_set_i = 0; bus_wr_i = 0;
    rd(4'h4, d);
    chk(d, 32'h0100, "R5 set wins over clear");
    wr(4'h4, 32'h1FFF);

    // R8: run self-clears on completion
    wr(4'h0, 32'h10000FFF);
    chk(run_o, 1, "R8 run set");
    @(negedge clk); core_done_i = 1;
    @(negedge clk); core_done_i = 0;
    chk(run_o, 0, "R8 run cleared by done");
    // completion and setting write in the same cycle
    @(negedge clk);
    core_done_i = 1; bus_wr_i = 1; bus_addr_i = 4'h0; bus_wdata_i = 32'h10000FFF;
    @(negedge clk);
    core_done_i = 0; bus_wr_i = 0;
    rd(4'h0, d);
    chk(d, 32'h00000FFF, "R8 done beats write");

    // R10: command dropped while idle
    @(negedge clk); bus_wr_i = 1; bus_addr_i = 4'h8; bus_wdata_i = 32'hA5A5_0001;
    @(negedge clk); bus_wr_i = 0;
    chk(cmd_vld_o, 0, "R10 no command when idle");
    wr(4'h0, 32'h10000FFF);
    @(negedge clk); bus_wr_i = 1; bus_addr_i = 4'h8; bus_wdata_i = 32'h1234_5678;
    @(negedge clk); bus_wr_i = 0;
    chk({31'd0, cmd_vld_o}, 1, "R10 command valid when running");
    chk(cmd_word_o, 32'h1234_5678, "R10 command word");
    @(negedge clk);
    chk(cmd_vld_o, 0, "R10 single pulse");

    // R11: resume pattern
    ev(13'h001F);
    @(negedge clk); clk_resume_i = 1;
    @(negedge clk); clk_resume_i = 0;
    rd(4'h4, d);
    chk(d, 32'h00001800, "R11 resume value");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule